// File: doc/BRIEF.md
# Four-Level Frame Sync Detector

This block watches a stream of already-decided four-level symbols in a receiver and reports where a frame begins. Each symbol arrives as a 2-bit code together with a one-cycle strobe. The block keeps the last 24 received symbols in a sliding window. On every strobe it compares that window with a fixed 24-symbol synchronization word. If the number of symbols that differ is within a programmable tolerance, it raises a one-cycle detect pulse.

The detector is live only while the receive-mode input is high. An optional polarity flip negates every incoming symbol before it enters the window. This lets a receiver whose frequency deviation is inverted still find frames. After a detection the window starts over, so two detections are always at least a full sync word apart.

Top module: `fsync_detect`

## Requirements
- R1: Symbol codes are +3 = 11, +1 = 10, -1 = 00 and -3 = 01. The sync word, in order of arrival, is -1 +1 -1 +1 -1 +3 -3 +3 -3 -1 +1 -3 +3 +3 -1 +1 -3 -3 +1 +3 -1 -3 +1 +3. When these 24 symbols arrive as the 24 most recent strobed symbols with tolerance 0, `detect` is 1 in the cycle after the strobe of the last one.
- R2: Tolerance code n (0 to 3, on `tol`) accepts a window that differs from the sync word in at most n symbol positions. A window with n+1 or more differing positions gives no detection.
- R3: A position counts as one mismatch whenever its 2-bit code differs from the expected code, whether one bit or both bits differ.
- R4: While `invert` is 1, each strobed symbol has its upper bit complemented (+3 and -3 swap, +1 and -1 swap) before it is stored and compared.
- R5: `detect` lasts exactly one cycle. It follows a clock edge at which `sym_valid` and `rx_mode` were both 1, and is 0 in every other cycle.
- R6: After a detection the window is emptied. No further detection occurs until 24 more symbols have been strobed.
- R7: While `rx_mode` is 0, strobes are ignored, no detection occurs and the window is emptied. After `rx_mode` returns to 1, 24 new symbols are needed before a detection.
- R8: After reset, no detection occurs before 24 symbols have been strobed in receive mode.
- R9: During and right after reset, `detect` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| rx_mode | input | 1 | 1 enables detection; 0 holds the window empty |
| invert | input | 1 | Negate the polarity of each incoming symbol |
| tol | input | 2 | Maximum number of mismatching symbols still accepted |
| sym_valid | input | 1 | One-cycle strobe marking a new symbol |
| sym | input | 2 | Decided symbol code |
| detect | output | 1 | One-cycle pulse on a sync word match |

## Verification
The bench builds the block with its default parameters: a 24-symbol word, 2-bit symbols and a 2-bit tolerance. At that size every tolerance code can be swept against every error count from 0 to 4, in both polarities. Each case places one-bit and two-bit corruptions at positions that change from case to case, so the accept/reject boundary is checked on both sides for every tolerance setting. A long stream of random symbols with embedded, partly corrupted sync words then checks every strobe against a model of the window. This stream also exercises detections back to back, the rearm gap and receive-mode dropouts in the middle of a word.

// File: rtl/fsync_detect.sv
module fsync_detect #(
  parameter int SYNC_LEN = 24,
  parameter int SYM_W = 2,
  parameter int TOL_W = 2,
  parameter logic [SYNC_LEN*SYM_W-1:0] SYNC_WORD = 48'h2237_49F2_5B1B
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_mode,
  input  logic             invert,
  input  logic [TOL_W-1:0] tol,
  input  logic             sym_valid,
  input  logic [SYM_W-1:0] sym,
  output logic             detect
);
  localparam int WIN_W  = SYNC_LEN * SYM_W;
  localparam int FILL_W = $clog2(SYNC_LEN);
  localparam int ERR_W  = $clog2(SYNC_LEN + 1);
  localparam logic [FILL_W-1:0] FILL_MAX = FILL_W'(SYNC_LEN - 1);

  logic [WIN_W-1:0]    win, win_next;
  logic [FILL_W-1:0]   fill;
  logic [SYM_W-1:0]    sym_in;
  logic [SYNC_LEN-1:0] miss;
  logic [ERR_W-1:0]    err;
  logic                hit;

  assign sym_in   = invert ? {~sym[SYM_W-1], sym[SYM_W-2:0]} : sym;
  assign win_next = {win[WIN_W-SYM_W-1:0], sym_in};

  for (genvar i = 0; i < SYNC_LEN; i++) begin : g_cmp
    assign miss[i] = win_next[i*SYM_W +: SYM_W] != SYNC_WORD[i*SYM_W +: SYM_W];
  end

  always_comb begin
    err = '0;
    for (int i = 0; i < SYNC_LEN; i++) err = err + ERR_W'(miss[i]);
  end

  assign hit = rx_mode && sym_valid && (fill == FILL_MAX) && (err <= ERR_W'(tol));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win    <= '0;
      fill   <= '0;
      detect <= 1'b0;
    end else begin
      detect <= hit;
      if (!rx_mode || hit) begin
        win  <= '0;
        fill <= '0;
      end else if (sym_valid) begin
        win <= win_next;
        if (fill != FILL_MAX) fill <= fill + 1'b1;
      end
    end
  end
endmodule

module fsync_detect_chk #(
  parameter int SYNC_LEN = 24
) (
  input logic clk,
  input logic rst_n,
  input logic rx_mode,
  input logic sym_valid,
  input logic detect
);
  localparam int CNT_W = $clog2(SYNC_LEN + 1);
  logic [CNT_W-1:0] seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen <= '0;
    else if (!rx_mode) seen <= '0;
    else if (detect) seen <= CNT_W'(sym_valid);
    else if (sym_valid && seen != CNT_W'(SYNC_LEN)) seen <= seen + 1'b1;
  end

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) detect |=> !detect); // R5
  AST_PULSE_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n) detect |-> $past(sym_valid)); // R5
  AST_ONLY_IN_RX: assert property (@(posedge clk) disable iff (!rst_n) detect |-> $past(rx_mode)); // R7
  AST_REARM_GAP: assert property (@(posedge clk) disable iff (!rst_n) detect |-> seen == CNT_W'(SYNC_LEN)); // R6
  AST_RESET_QUIET: assert property (@(posedge clk) $rose(rst_n) |-> !detect); // R9
endmodule

bind fsync_detect fsync_detect_chk #(.SYNC_LEN(SYNC_LEN)) chk_i (
  .clk(clk), .rst_n(rst_n), .rx_mode(rx_mode), .sym_valid(sym_valid), .detect(detect)
);

// File: tb/fsync_detect_tb.sv
module fsync_detect_tb_top;
  localparam logic [47:0] SW = 48'h2237_49F2_5B1B;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_mode = 1'b0, invert = 1'b0, sym_valid = 1'b0;
  logic [1:0] tol = 2'd0, sym = 2'd0;
  logic detect;

  int checks = 0, errors = 0;
  int mfill = 0;
  logic [1:0] mwin [24];

  always #5 clk = ~clk;

  fsync_detect dut_i (
    .clk(clk), .rst_n(rst_n), .rx_mode(rx_mode), .invert(invert), .tol(tol),
    .sym_valid(sym_valid), .sym(sym), .detect(detect)
  );

  function automatic logic [1:0] sync_sym(int j);
    return SW[47-2*j -: 2];
  endfunction

  task automatic chk(bit ok, string tag, logic act, logic exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s detect=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(bit v, logic [1:0] s, bit rx, bit inv, logic [1:0] t, string tag, output logic exp);
    logic [1:0] ss;
    int e;
    @(negedge clk);
    sym_valid = v; sym = s; rx_mode = rx; invert = inv; tol = t;
    @(posedge clk);
    #1;
    exp = 1'b0;
    if (!rx) mfill = 0;
    else if (v) begin
      ss = inv ? {~s[1], s[0]} : s;
      for (int i = 0; i < 23; i++) mwin[i] = mwin[i+1];
      mwin[23] = ss;
      if (mfill < 24) mfill++;
      if (mfill == 24) begin
        e = 0;
        for (int i = 0; i < 24; i++) if (mwin[i] != sync_sym(i)) e++;
        if (e <= int'(t)) begin exp = 1'b1; mfill = 0; end
      end
    end
    chk(detect === exp, tag, detect, exp);
  endtask

  task automatic send_word(int nerr, int seed, bit inv, logic [1:0] t, string tag, output logic last);
    logic [1:0] s;
    bit bad;
    logic ex;
    for (int j = 0; j < 24; j++) begin
      s = sync_sym(j);
      bad = 0;
      for (int k = 0; k < nerr; k++) if ((k * 7 + seed) % 24 == j) bad = 1;
      if (bad) s = s ^ ((j % 2) ? 2'b11 : 2'b01);
      if (inv) s = {~s[1], s[0]};
      step(1, s, 1, inv, t, tag, ex);
    end
    last = ex;
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic ex;
    logic last;
    for (int i = 0; i < 24; i++) mwin[i] = 2'b00;
    repeat (3) @(posedge clk);
    #1 chk(detect === 1'b0, "R9", detect, 1'b0);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #1 chk(detect === 1'b0, "R9", detect, 1'b0);

    // R8 / R1: exact word straight after reset, first 23 must stay quiet
    send_word(0, 0, 0, 2'd0, "R8", last);
    chk(last === 1'b1 && detect === 1'b1, "R1", detect, 1'b1);

    // R2 / R3 / R4: tolerance sweep in both polarities
    for (int inv = 0; inv < 2; inv++)
      for (int t = 0; t < 4; t++)
        for (int k = 0; k < 5; k++) begin
          step(0, 2'b00, 0, inv[0], t[1:0], "R7", ex);
          send_word(k, t + 3 * k + inv, inv[0], t[1:0], inv ? "R4" : "R3", last);
          chk(detect === (k <= t), "R2", detect, (k <= t));
        end

    // R4: uninverted word with inversion on must not match
    step(0, 2'b00, 0, 1, 2'd3, "R7", ex);
    for (int j = 0; j < 24; j++) step(1, sync_sym(j), 1, 1, 2'd3, "R4", ex);
    chk(detect === 1'b0, "R4", detect, 1'b0);

    // R6: back-to-back words detect twice; partial word after detect is quiet
    step(0, 2'b00, 0, 0, 2'd0, "R7", ex);
    send_word(0, 0, 0, 2'd0, "R6", last);
    send_word(0, 0, 0, 2'd0, "R6", last);
    chk(detect === 1'b1, "R6", detect, 1'b1);
    for (int j = 1; j < 24; j++) step(1, sync_sym(j), 1, 0, 2'd3, "R6", ex);
    step(0, 2'b00, 1, 0, 2'd3, "R5", ex);
    chk(detect === 1'b0, "R5", detect, 1'b0);

    // R7: word sent outside receive mode; dropout in the middle of a word
    for (int j = 0; j < 24; j++) step(1, sync_sym(j), 0, 0, 2'd0, "R7", ex);
    chk(detect === 1'b0, "R7", detect, 1'b0);
    for (int j = 0; j < 12; j++) step(1, sync_sym(j), 1, 0, 2'd3, "R7", ex);
    step(0, 2'b00, 0, 0, 2'd3, "R7", ex);
    for (int j = 12; j < 24; j++) step(1, sync_sym(j), 1, 0, 2'd3, "R7", ex);
    chk(detect === 1'b0, "R7", detect, 1'b0);

    // Random stream with embedded words, every strobe against the model
    for (int n = 0; n < 400; n++) begin
      int r;
      r = int'($urandom_range(0, 9));
      if (r == 0) send_word(int'($urandom_range(0, 3)), n, $urandom_range(0, 1) == 1, 2'($urandom_range(0, 3)), "R2", last);
      else if (r == 1) step(1, 2'($urandom), 0, 0, 2'($urandom), "R7", ex);
      else for (int j = 0; j < 8; j++)
        step($urandom_range(0, 3) != 0, 2'($urandom), 1, 0, 2'($urandom), "R5", ex);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule